// File: doc/BRIEF.md
# GPIO Unit with Grouped Interrupts

This block is a general-purpose I/O unit for up to 32 pins. Software reaches it through a simple word-addressed register port with one access per cycle. Each pin is set as an input or an output. An output pin holds a value that software writes. An input pin follows its synchronized pad level, and that level can be inverted per pin. A rising value on an input pin is latched in a sticky cause register.

The pins are split into groups of eight. Each group has one interrupt line, and these lines go to a system interrupt aggregator. A group line rises when an unmasked input pin in that group goes from 0 to 1. One global control bit sets how the line falls.

- In edge mode, the line falls when software rewrites the cause register so that the group's cause bits become all zero.
- In level mode, the line falls when a value bit in the group goes from 1 to 0 and the group's value bits are then all zero.

Top module: `gpio_grp_top`

## Requirements
- R1: After synchronous reset, all of these are zero: direction, polarity, value, cause, mask and mode, the `pin_val` output and every `grp_irq` line.
- R2: Register map by word address: direction 0, polarity 1, value 2, set 3, clear 4, cause 5, mask 6, mask alias 7, control 8. A direction bit of 1 makes the pin an output. A write to the value register changes only the output bits. Input bits always show the pin level, which is delayed by a two-stage synchronizer and lands on the third rising edge after the pad changes.
- R3: A write to the set register ORs the written bits into the output bits. A write to the clear register clears the written output bits. Input bits are not changed by either register, and both registers read as 0.
- R4: When a polarity bit is 1, that pin's synchronized input is inverted before it reaches the value register.
- R5: When the value bit of an input pin goes from 0 to 1, its cause bit is set. Cause bits stay set until software writes the cause register, which loads the written word.
- R6: If the pin's mask bit is 1, that rise also raises `grp_irq[pin/8]`. A rise on a masked-off pin leaves the group line unchanged.
- R7: Bit 10 of the control register selects level mode when it is 1 and edge mode when it is 0. The control register reads as 0x11FF0000 with bit 10 showing the mode.
- R8: In level mode, a 1-to-0 change of any value bit in a group drops that group's line if the group's value bits are all zero afterwards. If any bit in the group is still 1, the line stays up.
- R9: In edge mode, a cause write that changes a group's cause bits and leaves them all zero drops that group's line. A cause write that leaves the group's bits unchanged or nonzero keeps the line. In level mode, cause writes never drop a line.
- R10: Mask addresses 6 and 7 share one mask register. A write to either address reads back from both.
- R11: If a pin rise and a software cause write happen in the same cycle, the rise wins. The cause bit ends up set, and an unmasked group line is raised.
- R12: Output pins never set cause bits, and their pad levels never reach the value register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| pin_in | input | NPINS | Asynchronous pad levels |
| pin_val | output | NPINS | Value register, which drives the pads of output pins |
| grp_irq | output | NPINS/8 | One interrupt line per group of eight pins |

## Verification
The assertions assume that each pad level is held for at least two clocks, so the synchronizer sees a clean value. They also assume that the register port carries at most one write per cycle, with the address stable while it is read. The stimulus changes pads and register inputs only on falling clock edges and holds every pad pattern for at least three rising edges. The only exception is one deliberate case, where a cause write is placed on the edge at which a pad rise reaches the value register, to test the same-cycle priority.

// File: rtl/gpio_grp_pkg.sv
// Package: shared constants for the grouped-interrupt GPIO unit.
// Assumes a 32-bit register port, word-addressed with four address bits.
package gpio_grp_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 4;
    localparam int GRP_W    = 8;
    localparam int MODE_BIT = 10;

    localparam logic [ADDR_W-1:0] A_DIR    = 4'd0;
    localparam logic [ADDR_W-1:0] A_POL    = 4'd1;
    localparam logic [ADDR_W-1:0] A_VAL    = 4'd2;
    localparam logic [ADDR_W-1:0] A_SET    = 4'd3;
    localparam logic [ADDR_W-1:0] A_CLR    = 4'd4;
    localparam logic [ADDR_W-1:0] A_CAUSE  = 4'd5;
    localparam logic [ADDR_W-1:0] A_MASK_A = 4'd6;
    localparam logic [ADDR_W-1:0] A_MASK_B = 4'd7;
    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd8;

    localparam logic [DATA_W-1:0] CTRL_FIXED = 32'h11FF_0000;

    typedef enum logic {MODE_EDGE = 1'b0, MODE_LEVEL = 1'b1} irq_mode_e;
endpackage

// File: rtl/gpio_grp_sync.sv
// Two-flop synchronizer for a bus of independent asynchronous pad levels.
// Assumes each bit is sampled alone: there is no coherence between bits.
module gpio_grp_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two register stages for metastability settling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_async;
            sync_q <= meta_q;
        end
    end

    assign d_sync = sync_q;
endmodule

// File: rtl/gpio_grp_regs.sv
// Configuration and value registers, plus the read mux.
// Builds the next value word: output bits come from software
// (plain write, set, clear) and input bits come from the polarity-adjusted
// synchronized pads. Assumes at most one register access per cycle.
module gpio_grp_regs
    import gpio_grp_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NPINS-1:0]  pin_sync,
    input  logic [NPINS-1:0]  cause_q,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  mask_q,
    output logic [NPINS-1:0]  val_q,
    output logic [NPINS-1:0]  val_n,
    output logic              level_mode,
    output logic [DATA_W-1:0] rdata
);
    logic [NPINS-1:0] pol_q;
    logic [NPINS-1:0] pin_lvl;
    logic [NPINS-1:0] sw_val;
    logic [NPINS-1:0] wbits;
    irq_mode_e        mode_q;

    assign wbits      = wdata[NPINS-1:0];
    assign level_mode = (mode_q == MODE_LEVEL);

    // Configuration registers: direction, polarity, shared mask, mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            pol_q  <= '0;
            mask_q <= '0;
            mode_q <= MODE_EDGE;
        end else if (wr_en) begin
            case (addr)
                A_DIR:    dir_q  <= wbits;
                A_POL:    pol_q  <= wbits;
                A_MASK_A: mask_q <= wbits;
                A_MASK_B: mask_q <= wbits;
                A_CTRL:   mode_q <= wdata[MODE_BIT] ? MODE_LEVEL : MODE_EDGE;
                default:  ;
            endcase
        end
    end

    // Pad level after the optional per-pin inversion.
    assign pin_lvl = pin_sync ^ pol_q;

    // Software view of the output bits: plain write, set or clear.
    always_comb begin
        sw_val = val_q;
        if (wr_en) begin
            case (addr)
                A_VAL:   sw_val = wbits;
                A_SET:   sw_val = val_q | wbits;
                A_CLR:   sw_val = val_q & ~wbits;
                default: ;
            endcase
        end
    end

    // Next value: software owns the outputs, the pads own the inputs.
    assign val_n = (dir_q & sw_val) | (~dir_q & pin_lvl);

    // Value register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
        end else begin
            val_q <= val_n;
        end
    end

    // Read mux; set and clear addresses and unused addresses read zero.
    always_comb begin
        rdata = '0;
        case (addr)
            A_DIR:    rdata[NPINS-1:0] = dir_q;
            A_POL:    rdata[NPINS-1:0] = pol_q;
            A_VAL:    rdata[NPINS-1:0] = val_q;
            A_CAUSE:  rdata[NPINS-1:0] = cause_q;
            A_MASK_A: rdata[NPINS-1:0] = mask_q;
            A_MASK_B: rdata[NPINS-1:0] = mask_q;
            A_CTRL: begin
                rdata           = CTRL_FIXED;
                rdata[MODE_BIT] = level_mode;
            end
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_grp_irq.sv
// Cause register and per-group interrupt lines.
// A rising input-pin value sets its cause bit; a hardware set beats a
// same-cycle software cause write. Each group line is raised by an
// unmasked rise and dropped by the rule of the selected mode.
// Assumes val_n is the value the register will load on this edge.
module gpio_grp_irq
    import gpio_grp_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int NGRP  = NPINS / GRP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] val_q,
    input  logic [NPINS-1:0] val_n,
    input  logic [NPINS-1:0] dir_q,
    input  logic [NPINS-1:0] mask_q,
    input  logic             level_mode,
    input  logic             cause_wr,
    input  logic [NPINS-1:0] cause_wdata,
    output logic [NPINS-1:0] cause_q,
    output logic [NGRP-1:0]  grp_irq
);
    logic [NPINS-1:0] rise;
    logic [NPINS-1:0] fall;
    logic [NPINS-1:0] cause_n;

    // Edge detection on the value word; rises count only on input pins.
    assign rise = val_n & ~val_q & ~dir_q;
    assign fall = val_q & ~val_n;

    // Cause next state: software load first, then hardware sets on top.
    assign cause_n = (cause_wr ? cause_wdata : cause_q) | rise;

    // Cause register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
        end else begin
            cause_q <= cause_n;
        end
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int LO = g * GRP_W;
        logic set_g;
        logic drop_lvl;
        logic drop_edge;
        logic irq_q;

        // Raise and drop conditions for this group.
        always_comb begin
            set_g     = |(rise[LO +: GRP_W] & mask_q[LO +: GRP_W]);
            drop_lvl  = level_mode && (|fall[LO +: GRP_W]) &&
                        !(|val_n[LO +: GRP_W]);
            drop_edge = !level_mode && cause_wr &&
                        (cause_n[LO +: GRP_W] != cause_q[LO +: GRP_W]) &&
                        !(|cause_n[LO +: GRP_W]);
        end

        // Group line state: a set wins over any drop in the same cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                irq_q <= 1'b0;
            end else if (set_g) begin
                irq_q <= 1'b1;
            end else if (drop_lvl || drop_edge) begin
                irq_q <= 1'b0;
            end
        end

        assign grp_irq[g] = irq_q;
    end
endmodule

// File: rtl/gpio_grp_top.sv
// Top level of the grouped-interrupt GPIO unit. Connects the pad
// synchronizer, the register file and the cause/interrupt logic.
// Assumes NPINS is a multiple of eight and at most the data width.
module gpio_grp_top
    import gpio_grp_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int NGRP  = NPINS / GRP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_val,
    output logic [NGRP-1:0]   grp_irq
);
    logic [NPINS-1:0] pin_sync;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] mask_q;
    logic [NPINS-1:0] val_q;
    logic [NPINS-1:0] val_n;
    logic [NPINS-1:0] cause_q;
    logic             level_mode;
    logic             cause_wr;

    // Software write to the cause register.
    assign cause_wr = reg_wr && (reg_addr == A_CAUSE);

    gpio_grp_sync #(.W(NPINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_in),
        .d_sync  (pin_sync)
    );

    gpio_grp_regs #(.NPINS(NPINS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .pin_sync   (pin_sync),
        .cause_q    (cause_q),
        .dir_q      (dir_q),
        .mask_q     (mask_q),
        .val_q      (val_q),
        .val_n      (val_n),
        .level_mode (level_mode),
        .rdata      (reg_rdata)
    );

    gpio_grp_irq #(.NPINS(NPINS), .NGRP(NGRP)) u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .val_q       (val_q),
        .val_n       (val_n),
        .dir_q       (dir_q),
        .mask_q      (mask_q),
        .level_mode  (level_mode),
        .cause_wr    (cause_wr),
        .cause_wdata (reg_wdata[NPINS-1:0]),
        .cause_q     (cause_q),
        .grp_irq     (grp_irq)
    );

    assign pin_val = val_q;
endmodule

// File: rtl/gpio_grp_chk.sv
// Checker for gpio_grp_top, attached with bind. It observes the ports and
// the internal direction, cause and mode state.
module gpio_grp_chk
    import gpio_grp_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int NGRP  = NPINS / GRP_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [NPINS-1:0]  pin_val,
    input logic [NGRP-1:0]   grp_irq,
    input logic [NPINS-1:0]  dir_q,
    input logic [NPINS-1:0]  cause_q,
    input logic              level_mode
);
    logic sw_val_wr;
    logic sw_cause_wr;

    assign sw_val_wr   = reg_wr && (reg_addr == A_VAL || reg_addr == A_SET ||
                                    reg_addr == A_CLR);
    assign sw_cause_wr = reg_wr && (reg_addr == A_CAUSE);

    // R3: set and clear addresses read zero
    p_setclr_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_SET || reg_addr == A_CLR) |-> (reg_rdata == '0));

    // R7: control readback is the fixed pattern plus the mode bit
    p_ctrl_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_CTRL) |->
            ({reg_rdata[31:11], reg_rdata[9:0]} ==
             {CTRL_FIXED[31:11], CTRL_FIXED[9:0]}) &&
            (reg_rdata[MODE_BIT] == level_mode));

    // R2: without a value, set or clear write, output bits hold
    p_out_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_val_wr |=> (((pin_val ^ $past(pin_val)) & $past(dir_q)) == '0));

    // R5: cause bits are sticky unless software writes the cause register
    p_cause_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_cause_wr |=> (($past(cause_q) & ~cause_q) == '0));

    // R12: output pins never set cause bits
    p_out_no_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_cause_wr |=> ((cause_q & ~$past(cause_q) & $past(dir_q)) == '0));

    for (genvar g = 0; g < NGRP; g++) begin : g_chk
        // R6: a group line only rises together with a cause bit in its group
        p_irq_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(grp_irq[g]) |-> (|cause_q[g*GRP_W +: GRP_W]));
    end
endmodule

bind gpio_grp_top gpio_grp_chk #(.NPINS(NPINS), .NGRP(NGRP)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .pin_val    (pin_val),
    .grp_irq    (grp_irq),
    .dir_q      (dir_q),
    .cause_q    (cause_q),
    .level_mode (level_mode)
);

// File: tb/gpio_grp_top_tb.sv
`timescale 1ns/1ps
module gpio_grp_top_tb;
    import gpio_grp_pkg::*;

    localparam int NPINS = 32;
    localparam int NGRP  = NPINS / GRP_W;

    localparam logic [1:0] OP_WR  = 2'd0;
    localparam logic [1:0] OP_RD  = 2'd1;
    localparam logic [1:0] OP_PIN = 2'd2;
    localparam logic [1:0] OP_IRQ = 2'd3;

    // Each entry holds: op, address, data, expected value, requirement number.
    localparam int NVEC = 30;
    localparam logic [73:0] VEC [NVEC] = '{
        {OP_RD,  A_DIR,    32'h0,        32'h0,        4'd1},  // R1
        {OP_RD,  A_VAL,    32'h0,        32'h0,        4'd1},  // R1
        {OP_RD,  A_CAUSE,  32'h0,        32'h0,        4'd1},  // R1
        {OP_RD,  A_CTRL,   32'h0,        32'h11FF0000, 4'd7},  // R7
        {OP_IRQ, 4'd0,     32'h0,        32'h0,        4'd1},  // R1
        {OP_WR,  A_DIR,    32'h000000F0, 32'h0,        4'd2},  // R2
        {OP_WR,  A_VAL,    32'hFFFFFFFF, 32'h0,        4'd2},  // R2
        {OP_RD,  A_VAL,    32'h0,        32'h000000F0, 4'd2},  // R2
        {OP_PIN, 4'd0,     32'h00000FFF, 32'h0,        4'd12}, // R12
        {OP_RD,  A_VAL,    32'h0,        32'h00000FFF, 4'd12}, // R12
        {OP_RD,  A_CAUSE,  32'h0,        32'h00000F0F, 4'd12}, // R12, R5
        {OP_IRQ, 4'd0,     32'h0,        32'h0,        4'd6},  // R6
        {OP_WR,  A_CLR,    32'h000000FF, 32'h0,        4'd3},  // R3
        {OP_RD,  A_VAL,    32'h0,        32'h00000F0F, 4'd3},  // R3
        {OP_RD,  A_CLR,    32'h0,        32'h0,        4'd3},  // R3
        {OP_WR,  A_SET,    32'h00000030, 32'h0,        4'd3},  // R3
        {OP_RD,  A_VAL,    32'h0,        32'h00000F3F, 4'd3},  // R3
        {OP_RD,  A_SET,    32'h0,        32'h0,        4'd3},  // R3
        {OP_WR,  A_CAUSE,  32'h0,        32'h0,        4'd5},  // R5
        {OP_WR,  A_MASK_B, 32'h0000FF00, 32'h0,        4'd10}, // R10
        {OP_RD,  A_MASK_A, 32'h0,        32'h0000FF00, 4'd10}, // R10
        {OP_RD,  A_MASK_B, 32'h0,        32'h0000FF00, 4'd10}, // R10
        {OP_PIN, 4'd0,     32'h00001FFF, 32'h0,        4'd5},  // R5
        {OP_RD,  A_CAUSE,  32'h0,        32'h00001000, 4'd5},  // R5
        {OP_IRQ, 4'd0,     32'h0,        32'h00000002, 4'd6},  // R6
        {OP_WR,  A_POL,    32'h00010000, 32'h0,        4'd4},  // R4
        {OP_PIN, 4'd0,     32'h00001FFF, 32'h0,        4'd4},  // R4
        {OP_RD,  A_VAL,    32'h0,        32'h00011F3F, 4'd4},  // R4
        {OP_RD,  A_CAUSE,  32'h0,        32'h00011000, 4'd4},  // R4
        {OP_IRQ, 4'd0,     32'h0,        32'h00000002, 4'd6}   // R6 masked group 2 stays low
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              reg_wr;
    logic [ADDR_W-1:0] reg_addr;
    logic [DATA_W-1:0] reg_wdata;
    logic [DATA_W-1:0] reg_rdata;
    logic [NPINS-1:0]  pin_in;
    logic [NPINS-1:0]  pin_val;
    logic [NGRP-1:0]   grp_irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    gpio_grp_top #(.NPINS(NPINS)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pin_in    (pin_in),
        .pin_val   (pin_val),
        .grp_irq   (grp_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [ADDR_W-1:0] a,
                      input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic pins(input logic [31:0] p);
        @(negedge clk);
        pin_in = p[NPINS-1:0];
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic irq(input string tag, input logic [31:0] exp);
        @(negedge clk);
        chk(tag, {{(32-NGRP){1'b0}}, grp_irq}, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; pin_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 pin_val", pin_val, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            logic [1:0]  op;
            logic [3:0]  a;
            logic [31:0] d;
            logic [31:0] e;
            logic [3:0]  rq;
            {op, a, d, e, rq} = VEC[i];
            case (op)
                OP_WR:  wr(a, d);
                OP_RD:  rd($sformatf("R%0d vec%0d", rq, i), a, e);
                OP_PIN: pins(d);
                default: irq($sformatf("R%0d vec%0d", rq, i), e);
            endcase
        end

        // R9 edge mode: unchanged cause write keeps the line, clearing drops it
        wr(A_CAUSE, 32'h00011000);
        irq("R9 keep", 32'h2);
        wr(A_CAUSE, 32'h00010000);
        irq("R9 drop", 32'h0);

        // R7 / R8 level mode
        wr(A_CTRL, 32'h00000400);
        rd("R7 level", A_CTRL, 32'h11FF0400);
        pins(32'h00003FFF);
        irq("R8 raise", 32'h2);
        rd("R5 cause", A_CAUSE, 32'h00012000);
        wr(A_CAUSE, 32'h0);
        irq("R9 level no drop", 32'h2);
        pins(32'h00002FFF);
        irq("R8 partial fall keeps", 32'h2);
        pins(32'h000000FF);
        irq("R8 group zero drops", 32'h0);

        // R11 rise and cause write on the same edge
        wr(A_CTRL, 32'h0);
        @(negedge clk);
        pin_in = 32'h000001FF;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_CAUSE; reg_wdata = 32'h0;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        rd("R11 cause", A_CAUSE, 32'h00000100);
        irq("R11 irq", 32'h2);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule